// File: doc/BRIEF.md
# Byte-Wide Bus Bridge for 16-bit Timer Registers

This block sits between an 8-bit processor bus and a bank of 16-bit timer registers (a running counter, compare values, a capture value). Every 16-bit register appears as two byte addresses. One shared 8-bit holding byte makes each two-cycle byte transfer behave as one indivisible 16-bit operation. A read of the low byte takes a snapshot: the high half is copied into the holding byte in the same cycle, so a later high-byte read returns the value that belonged with the low byte, even if the counter has moved since. A write of the high byte only parks the data in the holding byte. The following low-byte write then delivers all sixteen bits to the register in one cycle.

Software must therefore read low then high, and write high then low. Because only one holding byte serves every register, an access to another register in the middle of a pair replaces the parked byte. The receiving register must give the one-cycle write strobe priority over its own hardware update in that cycle. Read data is registered and appears one cycle after the read strobe.

Top module: `wide_reg_bridge`

## Requirements
- R1: A read strobe at the low-byte address of register i sets bus_rdata to bits 7:0 of that register's live value on the next cycle, and loads bits 15:8 into the holding byte at the same clock edge.
- R2: A read strobe at the high-byte address returns the holding byte on bus_rdata on the next cycle, not the live high byte.
- R3: A write strobe at the high-byte address loads bus_wdata into the holding byte and asserts no register write strobe.
- R4: A write strobe at the low-byte address of register i asserts reg_wstb bit i, and only that bit, during that same cycle, with reg_wdata = {holding byte, bus_wdata}. The strobe drops in the next cycle unless a new write arrives.
- R5: Register i sits at BASE+2i (low byte) and BASE+2i+1 (high byte). A read outside that window returns 0x00 and leaves the holding byte unchanged. A write outside it asserts no strobe and leaves the holding byte unchanged.
- R6: One holding byte is shared by all registers. A low-byte read of any register, or a high-byte write of any register, replaces the parked byte for every other register.
- R7: While rst_n is low, and right after it rises, the holding byte is 0x00, bus_rdata is 0x00 and no strobe is asserted.
- R8: When bus_rd and bus_wr are both high, the write is performed and the read is ignored: bus_rdata keeps its previous value.
- R9: High-byte reads and low-byte writes leave the holding byte unchanged, so repeated low-byte writes reuse the same parked high byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_addr | input | ADDR_W | Byte address of the bus access |
| bus_wdata | input | DATA_W | Byte written by the bus |
| bus_rd | input | 1 | Read strobe, one access per cycle high |
| bus_wr | input | 1 | Write strobe, one access per cycle high |
| bus_rdata | output | DATA_W | Registered read byte, valid the cycle after bus_rd |
| reg_rval | input | NUM_REGS*2*DATA_W | Live values of all 16-bit registers, register 0 in the lowest bits |
| reg_wstb | output | NUM_REGS | One-cycle write strobe per register |
| reg_wdata | output | 2*DATA_W | Full word to write, shared by all registers |

## Verification
On every cycle, the assertions check the following: the low-byte read snapshot into the holding byte, high-byte reads returning the holding byte, the absence of strobes on high-byte and unmapped writes, the one-hot strobe, the write-over-read precedence, and the holding byte staying still when nothing loads it. Some behaviour needs a scenario, so only the bench can show it. A counter that moves between the two halves of a read still yields a matched pair. An interleaved access to another register corrupts a pending write with a foreign high byte. Repeated low-byte writes reuse one parked byte.

// File: rtl/wrb_pkg.sv
package wrb_pkg;

  // Width of a register index for a given register count (at least 1 bit).
  function automatic int idx_width(input int num_regs);
    return (num_regs > 1) ? $clog2(num_regs) : 1;
  endfunction

  // True when a byte address falls inside the bridge window.
  function automatic logic in_window(input int addr, input int base, input int num_regs);
    return (addr >= base) && (addr < base + 2 * num_regs);
  endfunction

  // Join the parked high byte and the bus byte into one word.
  function automatic logic [15:0] join_word(input logic [7:0] hi, input logic [7:0] lo);
    return {hi, lo};
  endfunction

endpackage

// File: rtl/wrb_decode.sv
module wrb_decode #(
  parameter int ADDR_W   = 8,
  parameter int NUM_REGS = 4,
  parameter int BASE     = 'h40,
  parameter int IDX_W    = 2
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit,
  output logic [IDX_W-1:0]  idx,
  output logic              hi_sel
);
  import wrb_pkg::*;

  logic [ADDR_W-1:0] offset;

  assign offset = addr - ADDR_W'(BASE);
  assign hit    = in_window(int'(addr), BASE, NUM_REGS);
  assign idx    = offset[IDX_W:1];
  assign hi_sel = offset[0];

endmodule

// File: rtl/wrb_rmux.sv
module wrb_rmux #(
  parameter int NUM_REGS = 4,
  parameter int WORD_W   = 16,
  parameter int IDX_W    = 2
) (
  input  logic [NUM_REGS*WORD_W-1:0] vals,
  input  logic [IDX_W-1:0]           idx,
  output logic [WORD_W-1:0]          word
);

  logic [WORD_W-1:0] words [NUM_REGS];

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_split
    assign words[g] = vals[g*WORD_W +: WORD_W];
  end

  always_comb begin
    word = '0;
    if (int'(idx) < NUM_REGS) word = words[idx];
  end

endmodule

// File: rtl/wrb_hold.sv
module wrb_hold #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_wr,
  input  logic [DATA_W-1:0] wr_byte,
  input  logic              ld_rd,
  input  logic [DATA_W-1:0] rd_byte,
  output logic [DATA_W-1:0] hold_q
);

  always_ff @(posedge clk) begin
    if (!rst_n)     hold_q <= '0;
    else if (ld_wr) hold_q <= wr_byte;
    else if (ld_rd) hold_q <= rd_byte;
  end

  // R9: nothing but a load moves the holding byte
  a_r9_hold_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld_wr && !ld_rd) |=> $stable(hold_q));

  // R3: a high-byte write parks the bus byte
  a_r3_hold_takes_write: assert property (@(posedge clk) disable iff (!rst_n)
    ld_wr |=> hold_q == $past(wr_byte));

endmodule

// File: rtl/wide_reg_bridge.sv
module wide_reg_bridge #(
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 8,
  parameter int NUM_REGS = 4,
  parameter int BASE     = 'h40
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [ADDR_W-1:0]              bus_addr,
  input  logic [DATA_W-1:0]              bus_wdata,
  input  logic                           bus_rd,
  input  logic                           bus_wr,
  output logic [DATA_W-1:0]              bus_rdata,
  input  logic [NUM_REGS*2*DATA_W-1:0]   reg_rval,
  output logic [NUM_REGS-1:0]            reg_wstb,
  output logic [2*DATA_W-1:0]            reg_wdata
);
  import wrb_pkg::*;

  localparam int WORD_W = 2 * DATA_W;
  localparam int IDX_W  = idx_width(NUM_REGS);

  logic              hit;
  logic              hi_sel;
  logic [IDX_W-1:0]  idx;
  logic [WORD_W-1:0] live_word;
  logic [DATA_W-1:0] hold_q;

  // Named bus events
  logic wr_act, rd_act;
  logic ev_rd_lo, ev_rd_hi, ev_wr_lo, ev_wr_hi;

  wrb_decode #(
    .ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS), .BASE(BASE), .IDX_W(IDX_W)
  ) i_decode (
    .addr(bus_addr), .hit(hit), .idx(idx), .hi_sel(hi_sel)
  );

  wrb_rmux #(
    .NUM_REGS(NUM_REGS), .WORD_W(WORD_W), .IDX_W(IDX_W)
  ) i_rmux (
    .vals(reg_rval), .idx(idx), .word(live_word)
  );

  assign wr_act   = rst_n && bus_wr && hit;
  assign rd_act   = rst_n && bus_rd && !bus_wr && hit;
  assign ev_wr_lo = wr_act && !hi_sel;
  assign ev_wr_hi = wr_act &&  hi_sel;
  assign ev_rd_lo = rd_act && !hi_sel;
  assign ev_rd_hi = rd_act &&  hi_sel;

  wrb_hold #(.DATA_W(DATA_W)) i_hold (
    .clk(clk), .rst_n(rst_n),
    .ld_wr(ev_wr_hi), .wr_byte(bus_wdata),
    .ld_rd(ev_rd_lo), .rd_byte(live_word[WORD_W-1:DATA_W]),
    .hold_q(hold_q)
  );

  // Registered read data
  always_ff @(posedge clk) begin
    if (!rst_n)                 bus_rdata <= '0;
    else if (bus_rd && !bus_wr) begin
      if (ev_rd_lo)      bus_rdata <= live_word[DATA_W-1:0];
      else if (ev_rd_hi) bus_rdata <= hold_q;
      else               bus_rdata <= '0;
    end
  end

  // Commit path: one strobe per register, shared data word
  for (genvar g = 0; g < NUM_REGS; g++) begin : g_stb
    assign reg_wstb[g] = ev_wr_lo && (int'(idx) == g);
  end

  if (DATA_W == 8) begin : g_join8
    assign reg_wdata = join_word(hold_q, bus_wdata);
  end else begin : g_join
    assign reg_wdata = {hold_q, bus_wdata};
  end

  // R1: low-byte read returns live low byte and snapshots the high byte
  a_r1_lo_read_snapshot: assert property (@(posedge clk) disable iff (!rst_n)
    ev_rd_lo |=> (hold_q == $past(live_word[WORD_W-1:DATA_W]))
              && (bus_rdata == $past(live_word[DATA_W-1:0])));

  // R2: high-byte read comes from the holding byte
  a_r2_hi_read_from_hold: assert property (@(posedge clk) disable iff (!rst_n)
    ev_rd_hi |=> bus_rdata == $past(hold_q));

  // R3: a high-byte write commits nothing
  a_r3_hi_write_no_commit: assert property (@(posedge clk) disable iff (!rst_n)
    ev_wr_hi |-> reg_wstb == '0);

  // R4: at most one register is written per cycle
  a_r4_single_target: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(reg_wstb));

  // R4: a high-then-low pair delivers the parked byte as the upper half
  a_r4_pair_commit: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_wr_lo && $past(ev_wr_hi)) |-> reg_wdata[WORD_W-1:DATA_W] == $past(bus_wdata));

  // R5: writes outside the window are dropped
  a_r5_unmapped_write_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !hit) |-> reg_wstb == '0);

  // R5: reads outside the window return zero
  a_r5_unmapped_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && !bus_wr && !hit) |=> bus_rdata == '0);

  // R8: a write in the same cycle cancels the read
  a_r8_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_wr) |=> $stable(bus_rdata));

endmodule

// File: tb/test_wide_reg_bridge.sv
module test_wide_reg_bridge;
  localparam int NUM  = 4;
  localparam int BASE = 'h40;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [7:0]  bus_wdata = '0;
  logic        bus_rd = 1'b0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_rdata;
  logic [NUM*16-1:0] reg_rval;
  logic [NUM-1:0]    reg_wstb;
  logic [15:0]       reg_wdata;

  always #2 clk = ~clk;  // 250 MHz

  wide_reg_bridge #(.NUM_REGS(NUM), .BASE(BASE)) i_wide_reg_bridge (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_rdata(bus_rdata),
    .reg_rval(reg_rval), .reg_wstb(reg_wstb), .reg_wdata(reg_wdata)
  );

  // Bench-side register file: bus strobe beats hardware load
  logic [15:0]    regs [NUM];
  logic [NUM-1:0] hw_ld = '0;
  logic [15:0]    hw_v  = '0;

  always @(posedge clk) begin
    for (int i = 0; i < NUM; i++) begin
      if (!rst_n)           regs[i] <= '0;
      else if (reg_wstb[i]) regs[i] <= reg_wdata;
      else if (hw_ld[i])    regs[i] <= hw_v;
    end
  end

  for (genvar g = 0; g < NUM; g++) begin : g_flat
    assign reg_rval[g*16 +: 16] = regs[g];
  end

  // Bench model
  logic [15:0] model [NUM];
  logic [7:0]  exp_hold;
  int total = 0;
  int bad   = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Scoreboard for read data
  logic [7:0] sb_data [$];
  string      sb_tag  [$];
  logic       mon_due = 1'b0;

  always @(posedge clk) mon_due <= bus_rd && !bus_wr;

  always @(negedge clk) begin
    if (mon_due) begin
      if (sb_data.size() == 0) chk("scoreboard underflow", 1, 0);
      else begin
        chk(sb_tag.pop_front(), {24'd0, bus_rdata}, {24'd0, sb_data.pop_front()});
      end
    end
  end

  task automatic read_raw(input logic [7:0] a, input logic [7:0] exp, input string tag);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1; bus_wr = 1'b0;
    sb_data.push_back(exp); sb_tag.push_back(tag);
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic read_lo(input int i, input string tag);
    logic [7:0] e;
    e = model[i][7:0];
    exp_hold = model[i][15:8];
    read_raw(8'(BASE + 2*i), e, tag);
  endtask

  task automatic read_hi(input int i, input string tag);
    read_raw(8'(BASE + 2*i + 1), exp_hold, tag);
  endtask

  task automatic write_hi(input int i, input logic [7:0] b, input string tag);
    @(negedge clk);
    bus_addr = 8'(BASE + 2*i + 1); bus_wdata = b; bus_wr = 1'b1;
    #1 chk({tag, " no strobe on high write"}, {28'd0, reg_wstb}, 0);
    exp_hold = b;
    @(negedge clk);
    bus_wr = 1'b0;
    chk({tag, " register untouched"}, {16'd0, regs[i]}, {16'd0, model[i]});
  endtask

  task automatic write_lo(input int i, input logic [7:0] b, input string tag);
    @(negedge clk);
    bus_addr = 8'(BASE + 2*i); bus_wdata = b; bus_wr = 1'b1;
    #1 chk({tag, " strobe"}, {28'd0, reg_wstb}, 32'(1 << i));
    chk({tag, " word"}, {16'd0, reg_wdata}, {16'd0, exp_hold, b});
    model[i] = {exp_hold, b};
    @(negedge clk);
    bus_wr = 1'b0;
    #1 chk({tag, " strobe one cycle"}, {28'd0, reg_wstb}, 0);
    chk({tag, " register value"}, {16'd0, regs[i]}, {16'd0, model[i]});
  endtask

  task automatic hw_load(input int i, input logic [15:0] v);
    @(negedge clk);
    hw_ld = '0; hw_ld[i] = 1'b1; hw_v = v;
    @(negedge clk);
    hw_ld = '0;
    model[i] = v;
  endtask

  // Watchdog
  initial begin
    repeat (20000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] prev;
    for (int i = 0; i < NUM; i++) model[i] = '0;
    exp_hold = '0;

    // R7: reset state
    repeat (4) @(negedge clk);
    chk("R7 rdata in reset", {24'd0, bus_rdata}, 0);
    chk("R7 strobes in reset", {28'd0, reg_wstb}, 0);
    rst_n = 1'b1;
    read_hi(0, "R7 holding byte after reset");

    // R1/R2: snapshot survives a counter change between the halves
    hw_load(1, 16'hABCD);
    read_lo(1, "R1 low byte");
    hw_load(1, 16'h1234);
    read_hi(1, "R2 high byte from snapshot");
    read_lo(1, "R1 low byte after change");
    read_hi(1, "R2 high byte after change");

    // R3/R4: high-then-low write commit
    write_hi(2, 8'h5A, "R3");
    write_lo(2, 8'h11, "R4");
    read_lo(2, "R4 readback low");
    read_hi(2, "R4 readback high");

    // R9: high reads and low writes keep the holding byte
    read_hi(2, "R9 repeated high read");
    write_lo(2, 8'h22, "R9 reuse parked byte");
    write_lo(3, 8'h33, "R9 second reuse");
    read_hi(0, "R9 hold after low writes");

    // R6: interleaved access corrupts a pending write
    write_hi(0, 8'h77, "R6 park");
    read_lo(1, "R6 foreign low read");
    write_lo(0, 8'h01, "R6 commit");
    chk("R6 corrupted high byte", {16'd0, regs[0]}, 32'h1201);

    // R5: unmapped accesses
    read_raw(8'h10, 8'h00, "R5 unmapped read below");
    read_raw(8'(BASE + 2*NUM), 8'h00, "R5 unmapped read above");
    read_hi(3, "R5 hold unchanged by unmapped read");
    @(negedge clk);
    bus_addr = 8'(BASE - 1); bus_wdata = 8'hEE; bus_wr = 1'b1;
    #1 chk("R5 no strobe below window", {28'd0, reg_wstb}, 0);
    @(negedge clk);
    bus_addr = 8'(BASE + 2*NUM + 1);
    #1 chk("R5 no strobe above window", {28'd0, reg_wstb}, 0);
    @(negedge clk);
    bus_wr = 1'b0;
    read_hi(3, "R5 hold unchanged by unmapped write");

    // R8: simultaneous read and write
    @(negedge clk);
    prev = bus_rdata;
    bus_addr = 8'(BASE + 6); bus_wdata = 8'h99; bus_rd = 1'b1; bus_wr = 1'b1;
    #1 chk("R8 write performed", {28'd0, reg_wstb}, 32'b1000);
    model[3] = {exp_hold, 8'h99};
    @(negedge clk);
    bus_rd = 1'b0; bus_wr = 1'b0;
    chk("R8 read ignored", {24'd0, bus_rdata}, {24'd0, prev});
    chk("R8 register value", {16'd0, regs[3]}, {16'd0, model[3]});
    read_lo(3, "R8 readback");

    repeat (3) @(negedge clk);
    chk("R1 scoreboard drained", sb_data.size(), 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule